// File: doc/BRIEF.md
# Mode-Selected Synchronous Ratio Clock Divider

This block turns one fast master clock into six phase-aligned output clocks: a processor clock, a half-rate memory reference, a 66-class clock, a bus clock, an interrupt-controller clock and an auxiliary (USB-class) clock. Each output is a registered square wave. A matching output-enable bit tells the pad ring whether to drive the wire or leave it at high impedance. Every output is produced by its own counter lane. All lanes restart together from one shared restart strobe, so all rising edges keep a common phase reference.

A three-bit mode word `mode` selects the operating state. Bit 2 selects the processor rate (1 = 133 class, 0 = 100 class). Bits 1 and 0 select among off, reserved, test and running states. In the running states bit 0 enables the auxiliary clock.

The master clock runs at 24 ticks per bus period (scaled by `SCALE`). At that rate every ratio in both running modes is an even tick count, which gives a 50% duty cycle. The 2/3 ratio of the 66-class clock becomes 12 ticks in both rates. The block has no data stream, so it has no valid/ready interface. All pins are plain control or clock pins, and `mode` is assumed synchronous to `clk`.

Top module: `ratio_clock_divider`

## Requirements
- R1: With `mode` = 3'b000, from the cycle after that value is sampled, all six `oe_o` bits are 0 and all six `clk_o` bits are 0.
- R2: With `mode[1:0]` = 2'b01 (codes 001 and 101, reserved), from the cycle after that value is sampled, all `oe_o` bits are 1 and all `clk_o` bits are held 0.
- R3: With `mode` = 3'b010 or 3'b011 (100 class), lanes 0..4 run with periods of 8, 16, 12, 24 and 48 ticks (times `SCALE`). Each lane is high for the first half of its period, and `oe_o[4:0]` are all 1. Lane index order: 0 processor, 1 memory reference, 2 66-class, 3 bus, 4 interrupt, 5 auxiliary.
- R4: With `mode` = 3'b110 or 3'b111 (133 class), lanes 0..4 run with periods of 6, 12, 12, 24 and 48 ticks (times `SCALE`), each at 50% duty, with `oe_o[4:0]` all 1.
- R5: With `mode` = 3'b100 (test), lanes 0..5 run with periods of 2, 4, 4, 8, 16 and 2 master-clock cycles, and all `oe_o` bits are 1.
- R6: In the running modes (`mode[1]` = 1), `mode[0]` = 1 makes lane 5 run with a period of `AUX_TICKS` ticks and `oe_o[5]` = 1. `mode[0]` = 0 makes `oe_o[5]` = 0 and `clk_o[5]` = 0.
- R7: On the clock edge where `mode` is sampled with a value different from the last one, every lane counter restarts. Every running lane is high in the cycle that follows, and its counting then starts from phase 0.
- R8: Outside a restart, every rising edge of the bus clock (lane 3) coincides with a rising edge of the processor clock (lane 0), and every rising edge of the interrupt clock (lane 4) coincides with a rising edge of the bus clock.
- R9: While `rst_n` is low, all `clk_o` and `oe_o` bits are 0, and the stored mode is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode word: bit 2 rate select, bits 1:0 state select |
| clk_o | output | 6 | Derived clocks, lanes 0..5 as listed in R3 |
| oe_o | output | 6 | Per-lane output enable; 0 means the pad is high impedance |

## Verification
The bound checker checks the following on every cycle:
- the off and reserved output states;
- the auxiliary lane going quiet when it is disabled;
- the pairs of lanes that must be identical in test mode and in 133 mode;
- the rule that a bus or interrupt rising edge is always accompanied by a rising edge one level faster.

Only the bench's reference model, which counts ticks since the last mode change, can show the following: the exact periods, the 50% duty, and the restart alignment after a mode change that arrives in the middle of a period.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int LANES  = 6;
  localparam int LN_CPU = 0;
  localparam int LN_MEM = 1;
  localparam int LN_M66 = 2;
  localparam int LN_BUS = 3;
  localparam int LN_IRQ = 4;
  localparam int LN_AUX = 5;

  typedef enum logic [1:0] {
    MC_OFF  = 2'd0,
    MC_HOLD = 2'd1,
    MC_TEST = 2'd2,
    MC_RUN  = 2'd3
  } mode_cls_e;

  function automatic mode_cls_e classify(input logic [2:0] m);
    mode_cls_e c;
    if (m == 3'b000)           c = MC_OFF;
    else if (m[1:0] == 2'b01)  c = MC_HOLD;
    else if (m == 3'b100)      c = MC_TEST;
    else                       c = MC_RUN;
    return c;
  endfunction

  // Period of one lane in master ticks for a given state and rate.
  function automatic int lane_period(input mode_cls_e c, input logic fast,
                                     input int lane, input int scale,
                                     input int aux);
    int cpu;
    int p;
    cpu = fast ? 6 * scale : 8 * scale;
    p = 2;
    if (c == MC_TEST) begin
      case (lane)
        LN_CPU:  p = 2;
        LN_MEM:  p = 4;
        LN_M66:  p = 4;
        LN_BUS:  p = 8;
        LN_IRQ:  p = 16;
        default: p = 2;
      endcase
    end else if (c == MC_RUN) begin
      case (lane)
        LN_CPU:  p = cpu;
        LN_MEM:  p = 2 * cpu;
        LN_M66:  p = 12 * scale;
        LN_BUS:  p = 24 * scale;
        LN_IRQ:  p = 48 * scale;
        default: p = aux;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/ratio_mode_decode.sv
module ratio_mode_decode
  import clkratio_pkg::*;
#(
  parameter int SCALE     = 1,
  parameter int AUX_TICKS = 16,
  parameter int CW        = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                mode,
  output logic                      restart,
  output logic [LANES-1:0]          run,
  output logic [LANES-1:0][CW-1:0]  period,
  output logic [LANES-1:0]          oe_q
);

  logic [2:0]       mode_q;
  mode_cls_e        cls;
  logic [LANES-1:0] oe_next;

  assign cls     = classify(mode);
  assign restart = (mode != mode_q);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i == LN_AUX)
        run[i] = (cls == MC_TEST) || ((cls == MC_RUN) && mode[0]);
      else
        run[i] = (cls == MC_TEST) || (cls == MC_RUN);
    end
  end

  always_comb begin
    case (cls)
      MC_OFF:  oe_next = '0;
      MC_HOLD: oe_next = '1;
      default: oe_next = run;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_per
    assign period[g] = CW'(lane_period(cls, mode[2], g, SCALE, AUX_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      oe_q   <= '0;
    end else begin
      mode_q <= mode;
      oe_q   <= oe_next;
    end
  end

endmodule

// File: rtl/ratio_lane.sv
module ratio_lane #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          clk_q
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] half;

  assign half = period >> 1;

  always_comb begin
    if (restart || (cnt == period - CW'(1)))
      cnt_n = '0;
    else
      cnt_n = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      clk_q <= (cnt_n < half);
    end
  end

endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
  import clkratio_pkg::*;
#(
  parameter int SCALE     = 1,
  parameter int AUX_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  output logic [LANES-1:0] clk_o,
  output logic [LANES-1:0] oe_o
);

  localparam int MAXP = (48 * SCALE > AUX_TICKS) ? 48 * SCALE : AUX_TICKS;
  localparam int CW   = $clog2(MAXP + 1);

  logic                     restart;
  logic [LANES-1:0]         run;
  logic [LANES-1:0][CW-1:0] period;

  ratio_mode_decode #(
    .SCALE     (SCALE),
    .AUX_TICKS (AUX_TICKS),
    .CW        (CW)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .restart (restart),
    .run     (run),
    .period  (period),
    .oe_q    (oe_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ratio_lane #(.CW(CW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (run[g]),
      .period  (period[g]),
      .clk_q   (clk_o[g])
    );
  end

endmodule

// File: rtl/ratio_clock_divider_chk.sv
module ratio_clock_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic [5:0] clk_o,
  input logic [5:0] oe_o,
  input logic       restart
);

  p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> (oe_o == 6'h00 && clk_o == 6'h00));

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b01) |=> (oe_o == 6'h3f && clk_o == 6'h00));

  p_mem_m66_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11) |=> (clk_o[1] == clk_o[2]));

  p_test_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100) |=> (clk_o[5] == clk_o[0] && clk_o[2] == clk_o[1]));

  p_aux_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !mode[0]) |=> (!oe_o[5] && !clk_o[5]));

  p_all_high_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (mode[1] || mode == 3'b100)) |=> (clk_o[4:0] == 5'h1f));

  p_bus_with_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_o[3]) && !$past(restart)) |-> $rose(clk_o[0]));

  p_irq_with_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_o[4]) && !$past(restart)) |-> $rose(clk_o[3]));

endmodule

bind ratio_clock_divider ratio_clock_divider_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .clk_o   (clk_o),
  .oe_o    (oe_o),
  .restart (restart)
);

// File: tb/ratio_clock_divider_tb_top.sv
`timescale 1ns/1ps
module ratio_clock_divider_tb_top;

  localparam int AUX = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [5:0] clk_o;
  logic [5:0] oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ratio_clock_divider #(.SCALE(1), .AUX_TICKS(AUX)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .clk_o (clk_o),
    .oe_o  (oe_o)
  );

  // Reference model: mode seen last and ticks since the last change.
  logic [2:0] mq = 3'b000;
  int         k  = 0;
  bit         rs = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq = 3'b000; k = 0; rs = 1'b0;
    end else if (mode != mq) begin
      mq = mode; k = 0; rs = 1'b1;
    end else begin
      k = (k + 1) % 48; rs = 1'b0;
    end
  end

  function automatic int ref_period(input logic [2:0] m, input int lane);
    int t[6];
    if (m == 3'b100)  t = '{2, 4, 4, 8, 16, 2};
    else if (m[2])    t = '{6, 12, 12, 24, 48, AUX};
    else              t = '{8, 16, 12, 24, 48, AUX};
    return t[lane];
  endfunction

  function automatic bit lane_on(input logic [2:0] m, input int lane);
    if (m == 3'b100) return 1'b1;
    if (!m[1])       return 1'b0;
    if (lane == 5)   return m[0];
    return 1'b1;
  endfunction

  function automatic string mtag(input logic [2:0] m);
    if (m == 3'b000)      return "R1";
    if (m[1:0] == 2'b01)  return "R2";
    if (m == 3'b100)      return "R5";
    if (m[2])             return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp,
                       input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  logic [5:0] prev_clk = '0;
  always @(negedge clk) begin
    logic [5:0] ec, eo;
    if (!rst_n) begin
      check("R9", clk_o, 6'h00, "clk in reset");
      check("R9", oe_o,  6'h00, "oe in reset");
    end else begin
      for (int i = 0; i < 6; i++) begin
        ec[i] = lane_on(mq, i) ? ((k % ref_period(mq, i)) < ref_period(mq, i) / 2) : 1'b0;
        if (mq == 3'b000)          eo[i] = 1'b0;
        else if (mq[1:0] == 2'b01) eo[i] = 1'b1;
        else                       eo[i] = lane_on(mq, i);
      end
      check(mtag(mq), {1'b0, clk_o[4:0]}, {1'b0, ec[4:0]}, "clk lanes 0..4");
      check(mtag(mq), {1'b0, oe_o[4:0]},  {1'b0, eo[4:0]}, "oe lanes 0..4");
      check((mq == 3'b100) ? "R5" : "R6", {5'b0, clk_o[5]}, {5'b0, ec[5]}, "aux clk");
      check((mq == 3'b100) ? "R5" : "R6", {5'b0, oe_o[5]},  {5'b0, eo[5]}, "aux oe");
      if (rs && lane_on(mq, 0))
        check("R7", {1'b0, clk_o[4:0]}, 6'h1f, "all high after restart");
      if (!rs && clk_o[3] && !prev_clk[3])
        check("R8", {5'b0, clk_o[0] && !prev_clk[0]}, 6'h01, "cpu rise with bus rise");
      if (!rs && clk_o[4] && !prev_clk[4])
        check("R8", {5'b0, clk_o[3] && !prev_clk[3]}, 6'h01, "bus rise with irq rise");
    end
    prev_clk = clk_o;
  end

  task automatic set_mode(input logic [2:0] m, input int cycles);
    @(negedge clk);
    mode = m;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    mode = 3'b011;             // R9: reset holds outputs low whatever the mode
    repeat (5) @(negedge clk);
    mode = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;
    set_mode(3'b000, 10);      // R1
    set_mode(3'b011, 200);     // R3, R6 aux on
    set_mode(3'b010, 100);     // R3, R6 aux off
    set_mode(3'b111, 200);     // R4
    set_mode(3'b110, 60);      // R4, R6
    set_mode(3'b100, 100);     // R5
    set_mode(3'b001, 20);      // R2
    set_mode(3'b101, 20);      // R2
    set_mode(3'b011, 5);       // R7: change in mid period
    set_mode(3'b111, 7);
    set_mode(3'b010, 3);
    set_mode(3'b100, 50);
    set_mode(3'b000, 10);      // R1
    set_mode(3'b111, 100);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

endmodule